// File: doc/BRIEF.md
# AXI4-Lite Register Bank with Access Strobes

This block is a small memory-mapped register bank reached through an AXI4-Lite slave port. It holds six word slots: a packed control word whose enable, mode and speed fields drive user logic, a full-word configuration register, a status word that mixes hardware-owned and software-owned bits, the two halves of a 64-bit hardware counter, and a write-only command word. The status word raises a one-cycle pulse each time software reads it and each time software writes it, so user logic can clear flags on read or start an action on a write.

Addresses are decoded relative to a base parameter inside a 32-byte window. The low counter word read also latches the upper half into a shadow register, so a low-then-high read pair returns one coherent 64-bit value. The control fields can be passed through a parameterised synchronizer chain (2 to 5 stages, on by default here) into a separate user clock. Every other output stays in the bus clock.

The bus side is one small state machine. States: `ST_IDLE` (ready for a request), `ST_WRESP` (write response pending), `ST_RDATA` (read data pending). Transitions: `ST_IDLE -> ST_WRESP` when write address and write data are both valid; `ST_IDLE -> ST_RDATA` when only a read address is valid; `ST_WRESP -> ST_IDLE` on `s_bready`; `ST_RDATA -> ST_IDLE` on `s_rready`. A write request wins over a read request in the same cycle.

Top module: `regbank_axil`

## Requirements
- R1: After reset the control word reads 0x00001021 (enable 1, mode 2, speed 0x10), the configuration word reads 0xCAFEBABE, the status flags, command word and counter shadow are zero, and no response is valid.
- R2: The control word is at offset 0x00 with enable in bit 0, mode in bits 5:4 and speed in bits 15:8; every other bit reads 0 and ignores writes. With synchronization enabled each field reaches its output after SYNC_STAGES user-clock edges.
- R3: The configuration word at offset 0x04 is read-write over all 32 bits; each set bit i of `s_wstrb` enables byte i of the write and cleared bytes keep their old value.
- R4: The status word at offset 0x08 returns `stat_hw` in bits 7:0 and the software flags in bits 23:16 (driven on `stat_flags`); writes update only bits 23:16 (byte lane 2) and never change bits 7:0; other bits read 0.
- R5: A read of the status word raises `stat_rd_pulse` for exactly one cycle, the cycle `s_rvalid` first rises; other reads give no pulse.
- R6: A write to the status word raises `stat_wr_pulse` for exactly one cycle, the cycle `s_bvalid` first rises; other writes give no pulse.
- R7: Offset 0x0C returns `count_in[31:0]` and copies `count_in[63:32]` into a shadow; offset 0x10 returns the shadow, so a later change of the counter does not alter the high word read after a low-word read.
- R8: The command word at offset 0x14 is write-only: writes (with byte strobes) drive `cmd_word`, reads return 0.
- R9: Reads of offsets 0x18 and 0x1C, of a non-word-aligned address, or of any address outside the window return 0 with OKAY; writes to them change no register.
- R10: Decoding is relative to BASE_ADDR: only addresses whose bits above bit 4 match BASE_ADDR reach a register.
- R11: A write is taken only when write address and data are valid together; `s_bvalid` and `s_rvalid` stay high until accepted; every response is OKAY (0); a write request beats a simultaneous read.
- R12: Writes to either counter word are ignored: the next read still returns the counter input and the held shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_clk | input | 1 | User-logic clock for synchronized control fields |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| ctl_enable | output | 1 | Control enable field (user clock) |
| ctl_mode | output | 2 | Control mode field (user clock) |
| ctl_speed | output | 8 | Control speed field (user clock) |
| cfg_word | output | 32 | Configuration register |
| stat_hw | input | 8 | Hardware status bits |
| stat_flags | output | 8 | Software status flags |
| stat_rd_pulse | output | 1 | One-cycle status read strobe |
| stat_wr_pulse | output | 1 | One-cycle status write strobe |
| count_in | input | 64 | Hardware counter value |
| cmd_word | output | 32 | Write-only command word |

## Verification
The assertions assume a manager that keeps its valid signals raised until accepted and never issues a new request while a response is still outstanding. They also assume `stat_hw` and `count_in` are steady around a read handshake unless a test changes them on purpose. The stimulus runs every transfer to completion through one request task and changes `count_in` only between transfers. The strobe-width and hold checks therefore rest on the one-request-at-a-time flow that the state machine enforces anyway.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int OFS_W  = 5;               // 32-byte window, eight word slots

    // word slots inside the window (index = offset / 4)
    typedef enum logic [2:0] {
        W_CTRL   = 3'd0,
        W_CFG    = 3'd1,
        W_STAT   = 3'd2,
        W_CNT_LO = 3'd3,
        W_CNT_HI = 3'd4,
        W_CMD    = 3'd5
    } word_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRESP = 2'd1,
        ST_RDATA = 2'd2
    } bus_st_e;

    // packed control word layout
    localparam int EN_POS    = 0;
    localparam int MODE_LSB  = 4;
    localparam int MODE_W    = 2;
    localparam int SPEED_LSB = 8;
    localparam int SPEED_W   = 8;
    localparam int CTLF_W    = 1 + MODE_W + SPEED_W;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_FF31;
    localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0000_1021;
    localparam logic [DATA_W-1:0] CFG_RST   = 32'hCAFE_BABE;

    // status word layout
    localparam int STAT_HW_W   = 8;
    localparam int STAT_FLG_LSB = 16;
    localparam int STAT_FLG_W  = 8;

    function automatic logic [DATA_W-1:0] byte_mask(input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < STRB_W; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

endpackage

// File: rtl/regbank_fsm.sv
module regbank_fsm
    import regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic awvalid,
    input  logic wvalid,
    input  logic arvalid,
    input  logic bready,
    input  logic rready,
    output logic awready,
    output logic wready,
    output logic arready,
    output logic bvalid,
    output logic rvalid,
    output logic wr_fire,
    output logic rd_fire
);

    bus_st_e st_q, st_d;
    logic    wr_req;

    assign wr_req = awvalid && wvalid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_req)       st_d = ST_WRESP;
                else if (arvalid) st_d = ST_RDATA;
            end
            ST_WRESP: if (bready) st_d = ST_IDLE;
            ST_RDATA: if (rready) st_d = ST_IDLE;
            default:              st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        arready = 1'b0;
        bvalid  = 1'b0;
        rvalid  = 1'b0;
        wr_fire = 1'b0;
        rd_fire = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                awready = wr_req;
                wready  = wr_req;
                arready = !wr_req;
                wr_fire = wr_req;
                rd_fire = !wr_req && arvalid;
            end
            ST_WRESP: bvalid = 1'b1;
            ST_RDATA: rvalid = 1'b1;
            default: ;
        endcase
    end

    // R11
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid);
    // R11
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R11
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> bvalid && !rvalid);

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic [STAT_HW_W-1:0] sts_hw,
    input  logic [2*DATA_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [CTLF_W-1:0] ctl_fields,
    output logic [DATA_W-1:0] cfg_word,
    output logic [STAT_FLG_W-1:0] flags,
    output logic [DATA_W-1:0] cmd_word,
    output logic              rd_stb,
    output logic              wr_stb
);

    logic [DATA_W-1:0] ctl_q, cfg_q, cmd_q, rdata_q, shadow_q, wmask;
    logic [STAT_FLG_W-1:0] flg_q;
    logic              rd_stb_q, wr_stb_q, w_hit, r_hit;
    logic [2:0]        widx, ridx;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]) && (a[1:0] == 2'b00);
    endfunction

    assign w_hit = in_window(waddr);
    assign r_hit = in_window(raddr);
    assign widx  = waddr[OFS_W-1:2];
    assign ridx  = raddr[OFS_W-1:2];
    assign wmask = byte_mask(wstrb);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= CTRL_RST;
            cfg_q    <= CFG_RST;
            flg_q    <= '0;
            cmd_q    <= '0;
            shadow_q <= '0;
            rdata_q  <= '0;
            rd_stb_q <= 1'b0;
            wr_stb_q <= 1'b0;
        end else begin
            rd_stb_q <= 1'b0;
            wr_stb_q <= 1'b0;
            if (wr_fire && w_hit) begin
                case (widx)
                    W_CTRL: ctl_q <= ((ctl_q & ~wmask) | (wdata & wmask)) & CTRL_MASK;
                    W_CFG:  cfg_q <= (cfg_q & ~wmask) | (wdata & wmask);
                    W_STAT: begin
                        if (wstrb[2]) flg_q <= wdata[STAT_FLG_LSB +: STAT_FLG_W];
                        wr_stb_q <= 1'b1;
                    end
                    W_CMD:  cmd_q <= (cmd_q & ~wmask) | (wdata & wmask);
                    default: ;
                endcase
            end
            if (rd_fire) begin
                rdata_q <= '0;
                if (r_hit) begin
                    case (ridx)
                        W_CTRL:   rdata_q <= ctl_q;
                        W_CFG:    rdata_q <= cfg_q;
                        W_STAT: begin
                            rdata_q  <= {8'h00, flg_q, 8'h00, sts_hw};
                            rd_stb_q <= 1'b1;
                        end
                        W_CNT_LO: begin
                            rdata_q  <= cnt[DATA_W-1:0];
                            shadow_q <= cnt[2*DATA_W-1:DATA_W];
                        end
                        W_CNT_HI: rdata_q <= shadow_q;
                        default:  rdata_q <= '0;
                    endcase
                end
            end
        end
    end

    assign rdata      = rdata_q;
    assign ctl_fields = {ctl_q[SPEED_LSB +: SPEED_W], ctl_q[MODE_LSB +: MODE_W], ctl_q[EN_POS]};
    assign cfg_word   = cfg_q;
    assign flags      = flg_q;
    assign cmd_word   = cmd_q;
    assign rd_stb     = rd_stb_q;
    assign wr_stb     = wr_stb_q;

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(cfg_q));
    // R5
    rd_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_q |=> !rd_stb_q);
    // R6
    wr_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |=> !wr_stb_q);
    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_fire && r_hit && ridx == W_CNT_LO) |=> $stable(shadow_q));

endmodule

// File: rtl/regbank_sync.sv
module regbank_sync #(
    parameter int             WIDTH  = 8,
    parameter int             STAGES = 2,
    parameter bit             EN     = 1'b1,
    parameter logic [WIDTH-1:0] RST  = '0
) (
    input  logic             dst_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (EN) begin : g_sync
            logic [WIDTH-1:0] pipe [STAGES];
            always_ff @(posedge dst_clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= RST;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[STAGES-1];
        end else begin : g_pass
            assign q = d;
        end
    endgenerate

    initial begin
        stage_range_chk: assert (STAGES >= 2 && STAGES <= 5);
    end

endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
    import regbank_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
    parameter bit                SYNC_EN     = 1'b1,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_clk,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              ctl_enable,
    output logic [1:0]        ctl_mode,
    output logic [7:0]        ctl_speed,
    output logic [31:0]       cfg_word,
    input  logic [7:0]        stat_hw,
    output logic [7:0]        stat_flags,
    output logic              stat_rd_pulse,
    output logic              stat_wr_pulse,
    input  logic [63:0]       count_in,
    output logic [31:0]       cmd_word
);

    localparam logic [CTLF_W-1:0] CTLF_RST =
        {CTRL_RST[SPEED_LSB +: SPEED_W], CTRL_RST[MODE_LSB +: MODE_W], CTRL_RST[EN_POS]};

    logic              wr_fire, rd_fire;
    logic [CTLF_W-1:0] ctl_bus, ctl_usr;

    regbank_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .wvalid  (s_wvalid),
        .arvalid (s_arvalid),
        .bready  (s_bready),
        .rready  (s_rready),
        .awready (s_awready),
        .wready  (s_wready),
        .arready (s_arready),
        .bvalid  (s_bvalid),
        .rvalid  (s_rvalid),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    regbank_store #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .waddr      (s_awaddr),
        .raddr      (s_araddr),
        .wdata      (s_wdata),
        .wstrb      (s_wstrb),
        .sts_hw     (stat_hw),
        .cnt        (count_in),
        .rdata      (s_rdata),
        .ctl_fields (ctl_bus),
        .cfg_word   (cfg_word),
        .flags      (stat_flags),
        .cmd_word   (cmd_word),
        .rd_stb     (stat_rd_pulse),
        .wr_stb     (stat_wr_pulse)
    );

    regbank_sync #(.WIDTH(CTLF_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST(CTLF_RST)) u_sync (
        .dst_clk (usr_clk),
        .rst_n   (rst_n),
        .d       (ctl_bus),
        .q       (ctl_usr)
    );

    assign ctl_enable = ctl_usr[0];
    assign ctl_mode   = ctl_usr[1 +: MODE_W];
    assign ctl_speed  = ctl_usr[1+MODE_W +: SPEED_W];
    assign s_bresp    = 2'b00;
    assign s_rresp    = 2'b00;

endmodule

// File: tb/regbank_axil_bench.sv
module regbank_axil_bench;

    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp, ctl_mode;
    logic [31:0] rdata, cfg_word, cmd_word;
    logic        ctl_enable, stat_rd_pulse, stat_wr_pulse;
    logic [7:0]  ctl_speed, stat_flags;
    logic [7:0]  stat_hw = 8'h5A;
    logic [63:0] count_in = 64'h1122_3344_5566_7788;

    always #10 clk = ~clk;   // 50 MHz

    regbank_axil #(.ADDR_W(AW), .BASE_ADDR(BASE), .SYNC_EN(1'b1), .SYNC_STAGES(2)) u_regbank_axil (
        .clk(clk), .rst_n(rst_n), .usr_clk(clk),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .ctl_enable(ctl_enable), .ctl_mode(ctl_mode), .ctl_speed(ctl_speed),
        .cfg_word(cfg_word), .stat_hw(stat_hw), .stat_flags(stat_flags),
        .stat_rd_pulse(stat_rd_pulse), .stat_wr_pulse(stat_wr_pulse),
        .count_in(count_in), .cmd_word(cmd_word)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of software-visible state
    logic [31:0] m_ctl = 32'h0000_1021, m_cfg = 32'hCAFE_BABE, m_cmd = '0, m_shadow = '0;
    logic [7:0]  m_flg = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic bit mapped(input logic [15:0] a);
        return (a[15:5] == BASE[15:5]) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        if (!mapped(a)) return 32'h0;
        case (a[4:2])
            3'd0: return m_ctl;
            3'd1: return m_cfg;
            3'd2: return {8'h00, m_flg, 8'h00, stat_hw};
            3'd3: return count_in[31:0];
            3'd4: return m_shadow;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] m;
        m = bmask(s);
        if (mapped(a)) begin
            case (a[4:2])
                3'd0: m_ctl = ((m_ctl & ~m) | (d & m)) & 32'h0000_FF31;
                3'd1: m_cfg = (m_cfg & ~m) | (d & m);
                3'd2: if (s[2]) m_flg = d[23:16];
                3'd5: m_cmd = (m_cmd & ~m) | (d & m);
                default: ;
            endcase
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
        bit stb_exp;
        stb_exp = mapped(a) && a[4:2] == 3'd2;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        #1;
        while (!(awready && wready)) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        model_wr(a, d, s);
        // R11 response valid and OKAY
        chk(bvalid === 1'b1 && bresp === 2'b00, "R11", {bvalid, bresp}, 3'b100);
        // R6 write strobe
        chk(stat_wr_pulse === stb_exp, "R6", stat_wr_pulse, stb_exp);
        bready = 1;
        @(posedge clk);
        @(negedge clk);
        bready = 0;
        chk(stat_wr_pulse === 1'b0 && bvalid === 1'b0, "R6", {stat_wr_pulse, bvalid}, 2'b00);
    endtask

    task automatic bus_rd(input logic [15:0] a, input string req);
        logic [31:0] e;
        bit stb_exp;
        stb_exp = mapped(a) && a[4:2] == 3'd2;
        @(negedge clk);
        araddr = a; arvalid = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        e = exp_rd(a);
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        if (mapped(a) && a[4:2] == 3'd3) m_shadow = count_in[63:32];
        chk(rvalid === 1'b1 && rdata === e && rresp === 2'b00, req, rdata, e);
        // R5 read strobe
        chk(stat_rd_pulse === stb_exp, "R5", stat_rd_pulse, stb_exp);
        rready = 1;
        @(posedge clk);
        @(negedge clk);
        rready = 0;
        chk(stat_rd_pulse === 1'b0 && rvalid === 1'b0, "R5", {stat_rd_pulse, rvalid}, 2'b00);
    endtask

    task automatic chk_fields();
        repeat (3) @(negedge clk);
        // R2 fields after synchronizer
        chk({ctl_speed, ctl_mode, ctl_enable} === {m_ctl[15:8], m_ctl[5:4], m_ctl[0]}, "R2",
            {ctl_speed, ctl_mode, ctl_enable}, {m_ctl[15:8], m_ctl[5:4], m_ctl[0]});
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            summary();
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
        pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state at the ports
        chk({ctl_enable, ctl_mode, ctl_speed} === {1'b1, 2'd2, 8'h10}, "R1",
            {ctl_enable, ctl_mode, ctl_speed}, {1'b1, 2'd2, 8'h10});
        chk(cfg_word === 32'hCAFE_BABE && stat_flags === 8'h00 && cmd_word === 32'h0, "R1",
            {cfg_word, stat_flags}, {32'hCAFE_BABE, 8'h00});
        chk(bvalid === 1'b0 && rvalid === 1'b0, "R1", {bvalid, rvalid}, 2'b00);
        bus_rd(BASE + 16'h00, "R1");
        bus_rd(BASE + 16'h04, "R1");
        bus_rd(BASE + 16'h10, "R1");

        // sweep every word slot with several patterns
        for (int w = 0; w < 8; w++) begin
            for (int p = 0; p < 4; p++) begin
                logic [15:0] a;
                a = BASE + 16'(w * 4);
                bus_wr(a, pats[p], 4'hF);
                if (w == 0) chk_fields();
                if (w == 1) chk(cfg_word === m_cfg, "R3", cfg_word, m_cfg);
                if (w == 2) chk(stat_flags === m_flg, "R4", stat_flags, m_flg);
                if (w == 5) chk(cmd_word === m_cmd, "R8", cmd_word, m_cmd);
                case (w)
                    0: bus_rd(a, "R2");
                    1: bus_rd(a, "R3");
                    2: bus_rd(a, "R4");
                    3, 4: bus_rd(a, "R12");
                    5: bus_rd(a, "R8");
                    default: bus_rd(a, "R9");
                endcase
            end
        end

        // R3 byte strobes on the configuration word
        bus_wr(BASE + 16'h04, 32'h0000_0000, 4'hF);
        bus_wr(BASE + 16'h04, 32'hFFFF_FFFF, 4'b0101);
        bus_rd(BASE + 16'h04, "R3");
        chk(cfg_word === 32'h00FF_00FF, "R3", cfg_word, 32'h00FF_00FF);
        // R2 partial strobe on the control word
        bus_wr(BASE + 16'h00, 32'hFFFF_FFFF, 4'b0001);
        chk_fields();
        bus_rd(BASE + 16'h00, "R2");

        // R4 status lane-2 only, hw bits track input
        bus_wr(BASE + 16'h08, 32'h00C3_0000, 4'b1011);
        bus_rd(BASE + 16'h08, "R4");
        stat_hw = 8'h96;
        bus_rd(BASE + 16'h08, "R4");

        // R7 coherent snapshot
        count_in = 64'hDEAD_0001_0000_FFFF;
        bus_rd(BASE + 16'h0C, "R7");
        count_in = 64'hBEEF_0002_0000_0000;
        bus_rd(BASE + 16'h10, "R7");
        bus_rd(BASE + 16'h10, "R7");
        bus_wr(BASE + 16'h10, 32'h5555_5555, 4'hF);
        bus_rd(BASE + 16'h10, "R12");

        // R9 R10 outside window and misaligned
        bus_wr(16'h2004, 32'h0BAD_0BAD, 4'hF);
        bus_rd(16'h2004, "R10");
        bus_rd(BASE + 16'h04, "R10");
        bus_wr(BASE + 16'h05, 32'h7777_7777, 4'hF);
        bus_rd(BASE + 16'h05, "R9");
        bus_rd(BASE + 16'h04, "R9");
        bus_rd(16'h0000, "R10");

        // R11 response hold and R5 single pulse while rready is low
        @(negedge clk);
        araddr = BASE + 16'h08; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        chk(stat_rd_pulse === 1'b1, "R5", stat_rd_pulse, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rvalid === 1'b1 && stat_rd_pulse === 1'b0, "R11", {rvalid, stat_rd_pulse}, 2'b10);
        end
        rready = 1;
        @(negedge clk);
        rready = 0;

        // R11 write beats read in the same cycle
        @(negedge clk);
        awaddr = BASE + 16'h14; wdata = 32'h0F0F_1234; wstrb = 4'hF; awvalid = 1; wvalid = 1;
        araddr = BASE + 16'h04; arvalid = 1;
        #1;
        chk(arready === 1'b0 && awready === 1'b1, "R11", {arready, awready}, 2'b01);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        model_wr(BASE + 16'h14, 32'h0F0F_1234, 4'hF);
        chk(bvalid === 1'b1 && rvalid === 1'b0, "R11", {bvalid, rvalid}, 2'b10);
        bready = 1;
        @(negedge clk);
        bready = 0;
        #1;
        chk(arready === 1'b1, "R11", arready, 1'b1);
        @(negedge clk);
        arvalid = 0;
        chk(rvalid === 1'b1 && rdata === m_cfg, "R11", rdata, m_cfg);
        rready = 1;
        @(negedge clk);
        rready = 0;
        chk(cmd_word === 32'h0F0F_1234, "R8", cmd_word, 32'h0F0F_1234);

        done = 1;
        summary();
    end

endmodule